// File: doc/BRIEF.md
# Debounced Pin Event Detector

This block watches the 16 input pins of a general-purpose I/O port and turns pin activity into latched interrupt requests. Each pin is brought into the clock domain by a two-flop synchronizer. A pin can then optionally go through a debounce filter. The filter samples at a programmable period, set as a power of two between 1 and 32768 ticks. The tick source is either the system clock or an external slow-tick enable. The filter output changes only after two consecutive sample points agree.

For each pin, the detector can look for rising edges, falling edges, both edges, a high level or a low level. A detected event sets a pending flag. Software clears a flag by writing a one to its bit. A single interrupt output is raised while any flag is pending. A per-pin input-disable mask forces a pin to read as zero and blocks all of its events.

Software reaches the block through a plain register port: a write strobe, a read strobe, a 3-bit word address and 32-bit data. Reads are combinational and return zero when the read strobe is low.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, every register reads 0 and irq_o is 0.
- R2: Register words and their fields:
  - Word 0: bits [3:0] hold the sample exponent n; bit 4 selects the slow tick (1) or the system clock (0); bit 5 selects always-on detection.
  - Word 1: per-pin debounce enable in bits [15:0].
  - Word 2: per-pin mode in bits [15:0], 0 for edge and 1 for level.
  - Word 3: falling/low enable for pin i at bit i, and rising/high enable at bit i+16.
  - Word 4: per-pin input disable in bits [31:16].
  - Word 5: pending flags in bits [15:0].
  - Word 6: the pin values after synchronization and disable masking, in bits [15:0].
  - Unused bits read 0.
- R3: In edge mode, a rising edge sets the pin's flag only if bit i+16 is set. A falling edge sets it only if bit i is set. With both bits set, both edges set it.
- R4: Without debounce, the pending flag is set at the third rising clock edge after the pin input changes.
- R5: In level mode, the flag is set while the enabled level (high for bit i+16, low for bit i) is present. Clearing the flag has no lasting effect while that level remains.
- R6: Writing word 5 clears exactly the flags whose data bits are 1. The other flags keep their value.
- R7: irq_o is 1 exactly when at least one pending flag is set.
- R8: A pin whose disable bit is set reads 0 in word 6 and sets no flag in any mode.
- R9: A debounced pin ignores a pulse shorter than the sample period 2^n. A steady change on that pin sets its flag between 2^n+3 and 2^n·2+4 cycles after the change. A pin without debounce passes a one-cycle pulse.
- R10: With the slow-tick source selected, the filter samples only in cycles where slow_tick_i is 1. A debounced change therefore needs two tick pulses to pass.
- R11: When the always-on bit is 0, the edge history of a pin is frozen while that pin has no enable set. When the always-on bit is 1, the history keeps tracking the pin.
- R12: If a clear write and a new event for the same pin land in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Asynchronous pin inputs |
| slow_tick_i | input | 1 | Single-cycle slow-tick enable for the debounce timer |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, 0 when reg_re_i is low |
| irq_o | output | 1 | OR of all pending flags |

## Verification
A corrupted synchronizer or edge-history bit shows up as a flag arriving one cycle early or late, or as a missing or extra flag. The bench pins these down by polling irq_o every cycle after a pin change, so such faults appear within three or four cycles. A wrong sample counter or filter register moves the debounced latency outside its window of 2^n to 2^(n+1) cycles. It can also let a short pulse through, which becomes visible after about two sample periods. Errors in the clear path or in a stored enable appear at the next read of word 5, since the interrupt line and the status word disagree with the stimulus at once.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned HI_OFS = 16;  // upper-half field offset

  typedef enum logic [ADDR_W-1:0] {
    A_DBCTL = 3'd0,
    A_DBEN  = 3'd1,
    A_TYPE  = 3'd2,
    A_IEN   = 3'd3,
    A_DOFF  = 3'd4,
    A_PEND  = 3'd5,
    A_PIN   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_evt_tick.sv
module gpio_evt_tick #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             slow_i,
  input  logic             tick_i,
  output logic             stb_o
);
  localparam int unsigned CW = (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q, lim;
  logic          adv;

  assign lim   = ~({CW{1'b1}} << sel_i);  // 2^n - 1
  assign adv   = slow_i ? tick_i : 1'b1;
  assign stb_o = adv && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (adv) cnt_q <= stb_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/gpio_evt_filt.sv
module gpio_evt_filt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic samp_q, filt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        samp_q <= 1'b0;
        filt_q <= 1'b0;
      end else if (stb_i) begin
        samp_q <= d_i[g];
        if (samp_q == d_i[g]) filt_q <= d_i[g];  // two agreeing samples
      end
    end

    assign q_o[g] = filt_q;
  end
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_lo_i,
  input  logic [W-1:0] en_hi_i,
  input  logic [W-1:0] off_i,
  input  logic         always_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] pend_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic prev_q, pend_q, act, hit;

    assign act = always_i | en_lo_i[g] | en_hi_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  prev_q <= 1'b0;
      else if (act) prev_q <= src_i[g];
    end

    always_comb begin
      if (lvl_i[g])
        hit = (src_i[g] & en_hi_i[g]) | (~src_i[g] & en_lo_i[g]);
      else
        hit = act & ((~prev_q & src_i[g] & en_hi_i[g]) |
                     (prev_q & ~src_i[g] & en_lo_i[g]));
    end

    assign evt_o[g] = hit & ~off_i[g];

    // new event takes priority over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= (pend_q & ~clr_i[g]) | evt_o[g];
    end

    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPIN  = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NPIN-1:0]   pend_i,
  input  logic [NPIN-1:0]   pin_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              src_slow_o,
  output logic              always_o,
  output logic [NPIN-1:0]   deb_en_o,
  output logic [NPIN-1:0]   lvl_o,
  output logic [NPIN-1:0]   en_lo_o,
  output logic [NPIN-1:0]   en_hi_o,
  output logic [NPIN-1:0]   off_o,
  output logic [NPIN-1:0]   clr_o
);
  localparam int unsigned SRC_BIT = SEL_W;
  localparam int unsigned ON_BIT  = SEL_W + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o      <= '0;
      src_slow_o <= 1'b0;
      always_o   <= 1'b0;
      deb_en_o   <= '0;
      lvl_o      <= '0;
      en_lo_o    <= '0;
      en_hi_o    <= '0;
      off_o      <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_DBCTL: begin
          sel_o      <= wdata_i[SEL_W-1:0];
          src_slow_o <= wdata_i[SRC_BIT];
          always_o   <= wdata_i[ON_BIT];
        end
        A_DBEN:  deb_en_o <= wdata_i[NPIN-1:0];
        A_TYPE:  lvl_o    <= wdata_i[NPIN-1:0];
        A_IEN: begin
          en_lo_o <= wdata_i[NPIN-1:0];
          en_hi_o <= wdata_i[HI_OFS +: NPIN];
        end
        A_DOFF:  off_o    <= wdata_i[HI_OFS +: NPIN];
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr_i == A_PEND) ? wdata_i[NPIN-1:0] : '0;

  logic [DW-1:0] rd;
  always_comb begin
    rd = '0;
    case (addr_i)
      A_DBCTL: begin
        rd[SEL_W-1:0] = sel_o;
        rd[SRC_BIT]   = src_slow_o;
        rd[ON_BIT]    = always_o;
      end
      A_DBEN:  rd[NPIN-1:0] = deb_en_o;
      A_TYPE:  rd[NPIN-1:0] = lvl_o;
      A_IEN: begin
        rd[NPIN-1:0]       = en_lo_o;
        rd[HI_OFS +: NPIN] = en_hi_o;
      end
      A_DOFF:  rd[HI_OFS +: NPIN] = off_o;
      A_PEND:  rd[NPIN-1:0] = pend_i;
      A_PIN:   rd[NPIN-1:0] = pin_i;
      default: rd = '0;
    endcase
  end

  assign rdata_o = re_i ? rd : '0;
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPIN  = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              slow_tick_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  logic [SEL_W-1:0] sel;
  logic             ctl_src, ctl_on, samp_stb;
  logic [NPIN-1:0]  deb_en, lvl, en_lo, en_hi, off, clr;
  logic [NPIN-1:0]  sync_w, din_w, filt_w, src_w, evt_w, pend_w;

  gpio_evt_regs #(.NPIN(NPIN), .DW(DW), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pend_i(pend_w), .pin_i(din_w),
    .sel_o(sel), .src_slow_o(ctl_src), .always_o(ctl_on),
    .deb_en_o(deb_en), .lvl_o(lvl), .en_lo_o(en_lo), .en_hi_o(en_hi),
    .off_o(off), .clr_o(clr)
  );

  gpio_evt_sync #(.W(NPIN)) u_sync (.clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_w));

  assign din_w = sync_w & ~off;

  gpio_evt_tick #(.SEL_W(SEL_W)) u_tick (
    .clk_i, .rst_ni, .sel_i(sel), .slow_i(ctl_src),
    .tick_i(slow_tick_i), .stb_o(samp_stb)
  );

  gpio_evt_filt #(.W(NPIN)) u_filt (
    .clk_i, .rst_ni, .stb_i(samp_stb), .d_i(din_w), .q_o(filt_w)
  );

  assign src_w = (deb_en & filt_w) | (~deb_en & din_w);

  gpio_evt_det #(.W(NPIN)) u_det (
    .clk_i, .rst_ni, .src_i(src_w), .lvl_i(lvl), .en_lo_i(en_lo),
    .en_hi_i(en_hi), .off_i(off), .always_i(ctl_on), .clr_i(clr),
    .evt_o(evt_w), .pend_o(pend_w)
  );

  assign irq_o = |pend_w;
endmodule

// File: rtl/gpio_evt_unit_chk.sv
module gpio_evt_unit_chk #(
  parameter int unsigned NPIN = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [2:0]      reg_addr_i,
  input logic [NPIN-1:0] clr_data_i,
  input logic            slow_tick_i,
  input logic            irq_o,
  input logic [NPIN-1:0] evt_i,
  input logic            stb_i,
  input logic [NPIN-1:0] filt_i,
  input logic            src_slow_i
);
  // R6: a full clear with no new event drops the interrupt
  p_clear_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd5 && (&clr_data_i) && !(|evt_i)) |=> !irq_o);

  // R6: the interrupt only falls after a status write
  p_fall_needs_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(reg_we_i && reg_addr_i == 3'd5));

  // R3: the interrupt only rises after a detected event
  p_rise_needs_evt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|evt_i));

  // R9: filtered values move only on sample strobes
  p_filt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(filt_i));

  // R10: no sampling without a slow tick when that source is chosen
  p_slow_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_slow_i && !slow_tick_i) |-> !stb_i);
endmodule

bind gpio_evt_unit gpio_evt_unit_chk #(.NPIN(NPIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .clr_data_i(reg_wdata_i[NPIN-1:0]), .slow_tick_i(slow_tick_i), .irq_o(irq_o),
  .evt_i(evt_w), .stb_i(samp_stb), .filt_i(filt_w), .src_slow_i(ctl_src)
);

// File: tb/gpio_evt_unit_tb.sv
module gpio_evt_unit_tb;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = '0;
  logic        slow_tick = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(PER/2) clk = ~clk;

  gpio_evt_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .slow_tick_i(slow_tick),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1 d = rdata;
    re = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin = '0; slow_tick = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int lat;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2 readback and field layout
    wr(3'd0, 32'hFFFF_FF2A); rd(3'd0, v); chk("R2 ctl", v, 32'h0000_002A);
    wr(3'd1, 32'hFFFF_1234); rd(3'd1, v); chk("R2 deb_en", v, 32'h0000_1234);
    wr(3'd2, 32'h5555_00F0); rd(3'd2, v); chk("R2 type", v, 32'h0000_00F0);
    wr(3'd3, 32'h8001_0002); rd(3'd3, v); chk("R2 ien", v, 32'h8001_0002);
    wr(3'd4, 32'hABCD_FFFF); rd(3'd4, v); chk("R2 doff", v, 32'hABCD_0000);
    @(negedge clk); addr = 3'd3; #1 chk("R2 no read strobe", rdata, 32'h0);
    rd(3'd7, v); chk("R2 unused word", v, 32'h0);

    // R3 edge sweep: mode 0 rise, 1 fall, 2 both
    do_reset();
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 16; i++) begin
        logic [31:0] bit_i, en;
        bit_i = 32'h1 << i;
        en = (m == 0) ? (bit_i << 16) : (m == 1) ? bit_i : (bit_i | (bit_i << 16));
        wr(3'd3, en);
        @(negedge clk); pin[i] = 1'b1;
        cyc(4); rd(3'd5, v);
        chk("R3 rise", v, (m != 1) ? bit_i : 32'h0);
        wr(3'd5, 32'hFFFF);
        @(negedge clk); pin[i] = 1'b0;
        cyc(4); rd(3'd5, v);
        chk("R3 fall", v, (m != 0) ? bit_i : 32'h0);
        wr(3'd5, 32'hFFFF);
        wr(3'd3, 32'h0);
      end
    end

    // R4 exact latency and R9 bypass of a one-cycle pulse
    do_reset();
    wr(3'd3, 32'h0002_0000);
    @(negedge clk); pin[1] = 1'b1;
    @(negedge clk); pin[1] = 1'b0;
    @(negedge clk); chk("R4 not before third edge", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R4 set at third edge R9 bypass", {31'b0, irq}, 32'h1);

    // R5 level sweep
    do_reset();
    wr(3'd2, 32'hFFFF);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] bit_i;
      bit_i = 32'h1 << i;
      wr(3'd3, bit_i << 16);
      @(negedge clk); pin[i] = 1'b1;
      cyc(4); rd(3'd5, v); chk("R5 high set", v, bit_i);
      wr(3'd5, 32'hFFFF); rd(3'd5, v); chk("R5 high resets after clear", v, bit_i);
      @(negedge clk); pin[i] = 1'b0;
      cyc(4); wr(3'd5, 32'hFFFF); rd(3'd5, v); chk("R5 high gone", v, 32'h0);
      wr(3'd3, bit_i);
      cyc(2); rd(3'd5, v); chk("R5 low set", v, bit_i);
      @(negedge clk); pin[i] = 1'b1;
      cyc(4); wr(3'd5, 32'hFFFF); rd(3'd5, v); chk("R5 low gone", v, 32'h0);
      @(negedge clk); pin[i] = 1'b0;
      wr(3'd3, 32'h0); cyc(3); wr(3'd5, 32'hFFFF);
    end

    // R6 selective clear, R7 interrupt OR
    do_reset();
    wr(3'd3, 32'h0208_0000);
    @(negedge clk); pin[3] = 1'b1; pin[9] = 1'b1;
    cyc(4); rd(3'd5, v); chk("R6 both set", v, 32'h0208);
    wr(3'd5, 32'h0008); rd(3'd5, v); chk("R6 only bit3 cleared", v, 32'h0200);
    chk("R7 irq with one flag", {31'b0, irq}, 32'h1);
    wr(3'd5, 32'h0200); rd(3'd5, v); chk("R6 all cleared", v, 32'h0);
    chk("R7 irq low", {31'b0, irq}, 32'h0);

    // R8 input disable
    do_reset();
    wr(3'd4, 32'h0020_0000);
    wr(3'd3, 32'h0060_0000);
    @(negedge clk); pin[5] = 1'b1; pin[6] = 1'b1;
    cyc(4); rd(3'd6, v); chk("R8 disabled pin reads 0", v, 32'h0040);
    rd(3'd5, v); chk("R8 disabled pin no edge", v, 32'h0040);
    wr(3'd5, 32'hFFFF);
    wr(3'd2, 32'h0020); wr(3'd3, 32'h0000_0020);
    cyc(4); rd(3'd5, v); chk("R8 disabled pin no low level", v, 32'h0);

    // R9 debounce on pin 0 with period 8 system clocks
    do_reset();
    wr(3'd0, 32'h3);
    wr(3'd1, 32'h1);
    wr(3'd3, 32'h0001_0000);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk); pin[0] = 1'b0;
    cyc(40); chk("R9 glitch rejected", {31'b0, irq}, 32'h0);
    @(negedge clk); pin[0] = 1'b1;
    lat = 0;
    while (!irq && lat < 100) begin @(negedge clk); lat++; end
    chk("R9 latency lower bound", {31'b0, (lat >= 11)}, 32'h1);
    chk("R9 latency upper bound", {31'b0, (lat <= 20)}, 32'h1);

    // R10 slow tick source
    do_reset();
    wr(3'd0, 32'h10);
    wr(3'd1, 32'h1);
    wr(3'd3, 32'h0001_0000);
    @(negedge clk); pin[0] = 1'b1;
    cyc(30); chk("R10 no tick no pass", {31'b0, irq}, 32'h0);
    @(negedge clk); slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    cyc(5); chk("R10 one tick not enough", {31'b0, irq}, 32'h0);
    @(negedge clk); slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    cyc(2); chk("R10 two ticks pass", {31'b0, irq}, 32'h1);

    // R11 gated vs always-on edge history
    do_reset();
    @(negedge clk); pin[2] = 1'b1;
    cyc(5); wr(3'd3, 32'h0004_0000);
    cyc(3); rd(3'd5, v); chk("R11 gated history stale", v, 32'h0004);
    do_reset();
    wr(3'd0, 32'h20);
    @(negedge clk); pin[2] = 1'b1;
    cyc(5); wr(3'd3, 32'h0004_0000);
    cyc(3); rd(3'd5, v); chk("R11 always-on history tracks", v, 32'h0);

    // R12 clear and event in the same cycle
    do_reset();
    wr(3'd3, 32'h0001_0001);
    @(negedge clk); pin[0] = 1'b1;
    cyc(4); wr(3'd5, 32'h1);
    @(negedge clk); pin[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd5; wdata = 32'h1;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(3'd5, v); chk("R12 event wins over clear", v, 32'h1);
    wr(3'd5, 32'h1); rd(3'd5, v); chk("R12 plain clear", v, 32'h0);

    finish_run();
  end
endmodule